// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Atomic Set/Clear Writes

This block drives the control lines of 32 general-purpose pads and samples their inputs. The pads are split into two banks of 16. The low bank holds pins 0 to 15 and the high bank holds pins 16 to 31. Each bank has eight per-pin configuration registers and one read-only input register. Both banks use the same layout of word offsets. The high bank's layout starts 0x80 bytes above the low bank's.

Software never needs a read-modify-write to change a pin. Every write to a configuration register carries two 16-bit masks. The lower half of the word turns bits on. The upper half turns bits off. Bits that neither half names keep their value.

The pad outputs come straight from the stored state. Output level, drive enable with open-drain handling, pull-up and pull-down are all derived from the registers. The input register shows each pad after a two-flop synchroniser, with input inversion applied and input enable used as a mask.

Top module: `gpio_setclr_top`

## Requirements
- R1: After reset every configuration register reads zero. The pad outputs pad_out, pad_oe, pad_pu and pad_pd are all zero.
- R2: A write to a configuration register with bit n of the lower half at 1 (and bit n+16 at 0) sets stored bit n. Bits whose set and clear bits are both 0 keep their value.
- R3: A write with bit n+16 at 1 clears stored bit n of the addressed register.
- R4: When a single write has both bit n and bit n+16 at 1, stored bit n ends at 0.
- R5: The bank is selected by address bit 7: 0 selects pins 0–15 and 1 selects pins 16–31. Pin p uses bit position p mod 16 inside its bank. A write to one bank never changes the other bank.
- R6: Configuration registers sit at byte offset 4*k within a bank, with k as follows: 0 output value, 1 output enable, 2 input enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input invert, 7 output invert. A read returns the stored bits in [15:0], and bits [31:16] of every read are zero.
- R7: pad_out for each pin equals output value XOR output invert.
- R8: pad_oe for each pin is high when output enable is set, except when open-drain is set and pad_out is 1, in which case it is low.
- R9: pad_pu and pad_pd follow the pull-up and pull-down registers bit for bit.
- R10: The read-only input register at byte offset 0x20 of a bank returns (sync(pad_in) XOR input invert) AND input enable. sync() is a two-flop delay, so a pad change shows in a read after two rising clock edges.
- R11: Writes to the input register, to offsets 0x24–0x7C, or to addresses with bits [1:0] not zero change no state. Reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write word: [15:0] set mask, [31:16] clear mask |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |

## Verification
The bench walks every bit of every register in both banks through set and clear. Two kinds of bug show up here: bank decode that aliases the two banks changes the wrong pin, and a swapped mask half inverts the result. Writes with the same pin named in both halves are aimed at the clear-wins rule; a set-priority design would leave those bits at 1.

A long series of random set/clear words checks every pad against per-pin arithmetic. This catches open-drain pins that still drive a high level and inversion applied to the wrong signal. Input reads are sampled exactly two edges after each pad change, so a synchroniser with one flop too few or too many shows a stale or early value.

Writes to the input register, to unused offsets and to unaligned addresses are checked for leaving every register and pad unchanged.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int FEAT_CNT   = 8;
  localparam int FEAT_VALUE = 0;
  localparam int FEAT_OE    = 1;
  localparam int FEAT_IE    = 2;
  localparam int FEAT_OD    = 3;
  localparam int FEAT_PU    = 4;
  localparam int FEAT_PD    = 5;
  localparam int FEAT_IINV  = 6;
  localparam int FEAT_OINV  = 7;
  localparam int FEAT_INPUT = 8;

  // level presented to the pad
  function automatic logic pad_level(input logic val, input logic inv);
    return val ^ inv;
  endfunction

  // drive enable: open-drain releases the pad when the level is high
  function automatic logic pad_drive(input logic oe, input logic od, input logic lvl);
    return oe & ~(od & lvl);
  endfunction

  // value seen by software for one synchronised input
  function automatic logic in_view(input logic s, input logic inv, input logic ie);
    return (s ^ inv) & ie;
  endfunction
endpackage

// File: rtl/gpio_feat_reg.sv
module gpio_feat_reg #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hit,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;
  assign set_m = wdata[W-1:0];
  assign clr_m = wdata[2*W-1:W];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [W-1:0] s,
                                         input logic [W-1:0] c);
    return (old | s) & ~c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_hit) q <= merge(q, set_m, clr_m);
  end

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & $past(set_m & clr_m)) == '0));
  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((~q & $past(set_m & ~clr_m)) == '0));
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & $past(clr_m)) == '0));
  assert_untouched_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((q ^ $past(q)) & ~$past(set_m | clr_m)) == '0));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // cycles since reset, saturating, so the delay check never reaches back past reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_two_flop_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_setclr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [FEAT_CNT-1:0]         wr_hit,
  input  logic [2*W-1:0]              wdata,
  input  logic [W-1:0]                pad_in,
  output logic [FEAT_CNT-1:0][W-1:0]  feat_q,
  output logic [W-1:0]                in_val,
  output logic [W-1:0]                pad_out,
  output logic [W-1:0]                pad_oe,
  output logic [W-1:0]                pad_pu,
  output logic [W-1:0]                pad_pd
);
  logic [W-1:0] synced;

  for (genvar f = 0; f < FEAT_CNT; f++) begin : g_feat
    gpio_feat_reg #(.W(W)) i_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[f]),
      .wdata  (wdata),
      .q      (feat_q[f])
    );
  end

  gpio_in_sync #(.W(W)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (synced)
  );

  for (genvar n = 0; n < W; n++) begin : g_pin
    assign pad_out[n] = pad_level(feat_q[FEAT_VALUE][n], feat_q[FEAT_OINV][n]);
    assign pad_oe[n]  = pad_drive(feat_q[FEAT_OE][n], feat_q[FEAT_OD][n], pad_out[n]);
    assign in_val[n]  = in_view(synced[n], feat_q[FEAT_IINV][n], feat_q[FEAT_IE][n]);
  end

  assign pad_pu = feat_q[FEAT_PU];
  assign pad_pd = feat_q[FEAT_PD];

  assert_od_releases_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & feat_q[FEAT_OD] & (feat_q[FEAT_VALUE] ^ feat_q[FEAT_OINV])) == '0));
  assert_oe_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~feat_q[FEAT_OE]) == '0));
  assert_input_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_val & ~feat_q[FEAT_IE]) == '0));
endmodule

// File: rtl/gpio_setclr_top.sv
module gpio_setclr_top
  import gpio_setclr_pkg::*;
#(
  parameter int BANK_W    = 16,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [2*BANK_W-1:0]           bus_wdata,
  output logic [2*BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_pu,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_pd
);
  localparam int DATA_W = 2 * BANK_W;
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int FIDX_W = ADDR_W - BSEL_W - 2;

  logic [BSEL_W-1:0] bsel;
  logic [FIDX_W-1:0] fidx;
  logic              aligned;

  assign bsel    = bus_addr[ADDR_W-1 -: BSEL_W];
  assign fidx    = bus_addr[ADDR_W-BSEL_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic [NUM_BANKS-1:0][FEAT_CNT-1:0][BANK_W-1:0] bank_feat;
  logic [NUM_BANKS-1:0][BANK_W-1:0]               bank_in;
  logic [NUM_BANKS-1:0][FEAT_CNT-1:0]             bank_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar f = 0; f < FEAT_CNT; f++) begin : g_hit
      assign bank_hit[b][f] = bus_wr && aligned &&
                              (bsel == BSEL_W'(b)) && (fidx == FIDX_W'(f));
    end

    gpio_bank #(.W(BANK_W)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (bank_hit[b]),
      .wdata   (bus_wdata),
      .pad_in  (pad_in[b*BANK_W +: BANK_W]),
      .feat_q  (bank_feat[b]),
      .in_val  (bank_in[b]),
      .pad_out (pad_out[b*BANK_W +: BANK_W]),
      .pad_oe  (pad_oe[b*BANK_W +: BANK_W]),
      .pad_pu  (pad_pu[b*BANK_W +: BANK_W]),
      .pad_pd  (pad_pd[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bsel == BSEL_W'(b)) begin
          for (int f = 0; f < FEAT_CNT; f++) begin
            if (fidx == FIDX_W'(f)) bus_rdata[BANK_W-1:0] = bank_feat[b][f];
          end
          if (fidx == FIDX_W'(FEAT_INPUT)) bus_rdata[BANK_W-1:0] = bank_in[b];
        end
      end
    end
  end

  assert_rdata_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[DATA_W-1:BANK_W] == '0));
  assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_unaligned_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (bus_rdata == '0 && bank_hit == '0));
endmodule

// File: tb/test_gpio_setclr_top.sv
module test_gpio_setclr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] mdl [2][8];
  logic [31:0] seed = 32'h1234_5679;

  always #5 clk = ~clk;

  gpio_setclr_top i_gpio_setclr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  function automatic logic [7:0] reg_addr(int b, int k);
    return 8'(b * 128 + k * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int b, k;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    b = int'(a[7]); k = int'(a[6:2]);
    if (a[1:0] == 2'b00 && k < 8)
      for (int n = 0; n < 16; n++) begin
        if (d[n])      mdl[b][k][n] = 1'b1;
        if (d[n + 16]) mdl[b][k][n] = 1'b0;
      end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_pads(string req);
    logic [31:0] e_out, e_oe, e_pu, e_pd;
    for (int p = 0; p < 32; p++) begin
      int b = p / 16;
      int n = p % 16;
      e_out[p] = (mdl[b][0][n] != mdl[b][7][n]);
      e_oe[p]  = mdl[b][1][n] && !(mdl[b][3][n] && e_out[p]);
      e_pu[p]  = mdl[b][4][n];
      e_pd[p]  = mdl[b][5][n];
    end
    chk({req, " R7 pad_out"}, pad_out, e_out);
    chk({req, " R8 pad_oe"}, pad_oe, e_oe);
    chk({req, " R9 pad_pu"}, pad_pu, e_pu);
    chk({req, " R9 pad_pd"}, pad_pd, e_pd);
  endtask

  task automatic check_all_regs(string req);
    logic [31:0] r;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) begin
        rd(reg_addr(b, k), r);
        chk(req, r, {16'h0, mdl[b][k]});
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d;
    for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) mdl[b][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all_regs("R1 reset register");
    chk("R1 reset pad_out", pad_out, '0);
    chk("R1 reset pad_oe", pad_oe, '0);
    chk("R1 reset pad_pu", pad_pu, '0);
    chk("R1 reset pad_pd", pad_pd, '0);

    // R2 R3 R5 R6: walk each bit of each register in both banks
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 16; n++) begin
          wr(reg_addr(b, k), 32'h1 << n);
          rd(reg_addr(b, k), r);
          chk("R2 set bit", r, {16'h0, mdl[b][k]});
          rd(reg_addr(1 - b, k), r);
          chk("R5 other bank untouched", r, {16'h0, mdl[1 - b][k]});
        end
    check_all_regs("R6 all set");
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 16; n += 3) begin
          wr(reg_addr(b, k), 32'h1 << (n + 16));
          rd(reg_addr(b, k), r);
          chk("R3 clear bit", r, {16'h0, mdl[b][k]});
        end

    // R4 both halves name the same pin
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) begin
        wr(reg_addr(b, k), 32'h00FF_FFFF);
        rd(reg_addr(b, k), r);
        chk("R4 clear wins", r, 32'h0000_FF00);
        chk("R4 model", {16'h0, mdl[b][k]}, 32'h0000_FF00);
      end

    // R7 R8 R9 random set/clear traffic
    for (int i = 0; i < 400; i++) begin
      next_rand(r);
      next_rand(d);
      wr(reg_addr(int'(r[3]), int'(r[2:0])), d);
      check_pads("random");
      rd(reg_addr(int'(r[3]), int'(r[2:0])), r);
    end
    check_all_regs("R6 after random");

    // R10 input path
    for (int i = 0; i < 60; i++) begin
      next_rand(r);
      if (i % 10 == 0) begin
        next_rand(d); wr(reg_addr(int'(d[0]), 2), d);
        next_rand(d); wr(reg_addr(int'(d[0]), 6), d);
      end
      @(negedge clk);
      pad_in = r;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
        logic [15:0] raw;
        raw = b ? r[31:16] : r[15:0];
        rd(reg_addr(b, 8), d);
        chk("R10 input view", d, {16'h0, (raw ^ mdl[b][6]) & mdl[b][2]});
      end
    end
    // one edge after a change the old value must still show
    wr(reg_addr(0, 2), 32'h0000_FFFF);
    wr(reg_addr(0, 6), 32'hFFFF_0000);
    @(negedge clk); pad_in = 32'h0; @(posedge clk); @(posedge clk); @(negedge clk);
    pad_in = 32'h0000_A5A5;
    @(posedge clk); @(negedge clk);
    rd(reg_addr(0, 8), d);
    chk("R10 not yet after one edge", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(reg_addr(0, 8), d);
    chk("R10 visible after two edges", d, 32'h0000_A5A5);

    // R11 writes with no effect, reads of unmapped space
    wr(reg_addr(0, 1), 32'h0000_FFFF);
    wr(reg_addr(1, 0), 32'h0000_3C3C);
    wr(reg_addr(0, 8), 32'h0000_FFFF);
    wr(reg_addr(1, 8), 32'hFFFF_0000);
    for (int k = 9; k < 32; k += 2) begin
      wr(reg_addr(0, k), 32'hFFFF_0000);
      wr(reg_addr(1, k), 32'h0000_FFFF);
      rd(reg_addr(k % 2, k), r);
      chk("R11 unmapped read zero", r, 32'h0);
    end
    wr(reg_addr(0, 1) + 8'd1, 32'hFFFF_0000);
    wr(reg_addr(1, 0) + 8'd2, 32'hFFFF_0000);
    rd(reg_addr(0, 1) + 8'd3, r);
    chk("R11 unaligned read zero", r, 32'h0);
    check_all_regs("R11 state kept");
    check_pads("R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule